// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer Bank

This block holds five 16-bit timers that count down, each with its own tick rate. Each timer keeps a pending count value and a pending compare value in buffer registers. Software writes the buffers and then commits them to the running counter in one of two ways: it pulses a manual-update bit, or it leaves the counter to reload itself each time it reaches zero. While a timer runs, its output is low from the load until the counter steps onto the compare value. The output then stays high until the counter reaches zero. A per-timer invert bit flips this level. Timers 0 to 3 each drive one output pin. Timer 4 has no pin, and software watches it through its live counter value.

Two 8-bit prescalers divide the bus clock. Timers 0 and 1 share the first prescaler, and timers 2 to 4 share the second. Each timer then divides its prescaler tick again by 2, 4, 8 or 16. All settings go through a simple write port that takes effect in one cycle. Reads come back on a read port with no wait states.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset, every register reads zero, every active counter is zero and every pin is low.
- R2: The shared control register at address 2 has a 4-bit field per timer. Timer 0's field is at bits 3:0. Timer n (n at least 1) has its field at bits 4n+7:4n+4. Within a field, bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload. Bits 7:4 and bits 31:24 always read zero.
- R3: Timer n's count buffer is at address 4+n and its compare buffer is at address 9+n. Both keep the low 16 bits of a write and read them back. Address 16+n reads the live counter of timer n, and writes to that address have no effect.
- R4: While a timer's manual-update bit is 1, its active counter and active compare are loaded from the buffers, its output returns to the low (pre-invert) level, and its tick divider restarts.
- R5: Address 0 holds the prescaler values: bits 7:0 serve timers 0 and 1, and bits 15:8 serve timers 2 to 4. A prescaler gives one tick every value+1 bus clocks. Address 1 holds a 2-bit divider select per timer at bits 2n+1:2n. Select values 0, 1, 2 and 3 divide the prescaler tick by 2, 4, 8 and 16.
- R6: A started timer decrements once per divided tick. A timer whose start bit is 0 holds its counter.
- R7: Before inversion, the output goes high when a decrement lands on the compare value, and it stays high until the counter is zero. The match is tested only after a decrement. So a compare equal to the loaded count, or a compare of zero, never drives the output high.
- R8: With auto-reload set, the tick after the counter reaches zero reloads the counter and compare from the buffers. The period is therefore count+1 ticks, and the output is high for compare ticks of each period.
- R9: With auto-reload clear, a timer that reaches zero holds at zero, and its output stays at the inactive level.
- R10: A buffer write does not change the running counter until the next reload or manual update.
- R11: The invert bit makes each pin the complement of its pre-invert level.
- R12: Timer 4 counts like the others. It drives no pin, and its count is seen only at its live-counter address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pwm_out | output | 4 | Output pins of timers 0 to 3 |

## Verification
The assertions assume that software keeps a manual-update bit high only while the timer is meant to be held at its buffer values. They also assume that prescaler values are not changed while the block is checking tick spacing. The stimulus follows the intended sequence for every load: first a write that sets the manual-update bit with start clear, then a write that clears it and sets start. Prescaler and divider settings are written only while the affected timer is stopped. Duty is measured by counting high cycles over exactly four whole periods. This makes each result independent of the divider phase at the moment of loading.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int FLD_START = 0;
    localparam int FLD_UPD   = 1;
    localparam int FLD_INV   = 2;
    localparam int FLD_AUTO  = 3;

    typedef struct packed {
        logic auto_rl;
        logic inv;
        logic upd;
        logic start;
    } chan_ctrl_t;

    // Bit position of a timer's field in the shared control register
    function automatic int field_base(input int t);
        return (t == 0) ? 0 : 4 * t + 4;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q >= div_i);

    always_comb begin
        cnt_d = cnt_q + W'(1);
        if (tick_o) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: with a divide value above zero, ticks never come back to back
    a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> (!tick_o || div_i != $past(div_i)));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_tick_i,
    input  logic [SEL_W-1:0] sel_i,
    input  chan_ctrl_t       ctl_i,
    input  logic [CNT_W-1:0] cnt_buf_i,
    input  logic [CNT_W-1:0] cmp_buf_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             level_o
);
    localparam int DIV_W = 1 << SEL_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic             hit;
        logic [DIV_W-1:0] div;
    } chan_state_t;

    chan_state_t st_d, st_q;

    logic [DIV_W:0]   mask_w;
    logic [DIV_W-1:0] mask;
    logic             tick;
    logic [CNT_W-1:0] dec;
    logic             raw;

    always_comb begin
        mask_w = ((DIV_W + 1)'(2) << sel_i) - (DIV_W + 1)'(1);
        mask   = mask_w[DIV_W-1:0];
        tick   = pre_tick_i && ((st_q.div & mask) == mask);
        dec    = st_q.cnt - CNT_W'(1);
        st_d   = st_q;
        if (ctl_i.upd) begin
            st_d.cnt = cnt_buf_i;
            st_d.cmp = cmp_buf_i;
            st_d.hit = 1'b0;
            st_d.div = '0;
        end else if (ctl_i.start) begin
            if (pre_tick_i) st_d.div = st_q.div + DIV_W'(1);
            if (tick) begin
                if (st_q.cnt == '0) begin
                    if (ctl_i.auto_rl) begin
                        st_d.cnt = cnt_buf_i;
                        st_d.cmp = cmp_buf_i;
                        st_d.hit = 1'b0;
                    end
                end else begin
                    st_d.cnt = dec;
                    if (dec == st_q.cmp) st_d.hit = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw     = st_q.hit && (st_q.cnt != '0);
    assign level_o = raw ^ ctl_i.inv;
    assign cnt_o   = st_q.cnt;

    // R4: an update loads the buffered count and clears the output level
    a_r4_manual_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.upd |=> (st_q.cnt == $past(cnt_buf_i)) && !raw);

    // R6: a stopped timer holds its count
    a_r6_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_i.start && !ctl_i.upd) |=> $stable(st_q.cnt));

    // R8: away from zero and updates, the count never rises
    a_r8_never_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_i.upd && st_q.cnt != '0) |=> (st_q.cnt <= $past(st_q.cnt)));

    // R9: without auto-reload, zero is terminal
    a_r9_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_i.upd && !ctl_i.auto_rl && st_q.cnt == '0) |=> (st_q.cnt == '0));

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_TIMERS = 5,
    parameter int NUM_PINS   = 4,
    parameter int CNT_W      = 16,
    parameter int PRE_W      = 8,
    parameter int SEL_W      = 2,
    parameter int SPLIT      = 2,
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_PINS-1:0] pwm_out
);
    localparam int CTRL_W = 4 * NUM_TIMERS + 4;
    localparam int A_PRE  = 0;
    localparam int A_SEL  = 1;
    localparam int A_CTRL = 2;
    localparam int A_CNTB = 4;
    localparam int A_CMPB = A_CNTB + NUM_TIMERS;
    localparam int A_LIVE = 16;
    localparam logic [CTRL_W-1:0] CTRL_MASK = ~{{(CTRL_W - 8){1'b0}}, 8'hF0};

    typedef struct packed {
        logic [1:0][PRE_W-1:0]             pre;
        logic [NUM_TIMERS*SEL_W-1:0]       sel;
        logic [CTRL_W-1:0]                 ctrl;
        logic [NUM_TIMERS-1:0][CNT_W-1:0]  cntb;
        logic [NUM_TIMERS-1:0][CNT_W-1:0]  cmpb;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0]                       pre_tick;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] live;
    logic [NUM_TIMERS-1:0]            level;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(A_PRE))  r_d.pre  = wr_data[2*PRE_W-1:0];
            if (wr_addr == ADDR_W'(A_SEL))  r_d.sel  = wr_data[NUM_TIMERS*SEL_W-1:0];
            if (wr_addr == ADDR_W'(A_CTRL)) r_d.ctrl = wr_data[CTRL_W-1:0] & CTRL_MASK;
            for (int t = 0; t < NUM_TIMERS; t++) begin
                if (wr_addr == ADDR_W'(A_CNTB + t)) r_d.cntb[t] = wr_data[CNT_W-1:0];
                if (wr_addr == ADDR_W'(A_CMPB + t)) r_d.cmpb[t] = wr_data[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_PRE))  rd_data = DATA_W'(r_q.pre);
        if (rd_addr == ADDR_W'(A_SEL))  rd_data = DATA_W'(r_q.sel);
        if (rd_addr == ADDR_W'(A_CTRL)) rd_data = DATA_W'(r_q.ctrl);
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (rd_addr == ADDR_W'(A_CNTB + t)) rd_data = DATA_W'(r_q.cntb[t]);
            if (rd_addr == ADDR_W'(A_CMPB + t)) rd_data = DATA_W'(r_q.cmpb[t]);
            if (rd_addr == ADDR_W'(A_LIVE + t)) rd_data = DATA_W'(live[t]);
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_pre
        pwm_prescaler #(.W(PRE_W)) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .div_i  (r_q.pre[p]),
            .tick_o (pre_tick[p])
        );
    end

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_chan
        localparam int FB = field_base(t);
        localparam int PS = (t < SPLIT) ? 0 : 1;
        chan_ctrl_t ctl;
        assign ctl.start   = r_q.ctrl[FB + FLD_START];
        assign ctl.upd     = r_q.ctrl[FB + FLD_UPD];
        assign ctl.inv     = r_q.ctrl[FB + FLD_INV];
        assign ctl.auto_rl = r_q.ctrl[FB + FLD_AUTO];

        pwm_channel #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .pre_tick_i (pre_tick[PS]),
            .sel_i      (r_q.sel[t*SEL_W +: SEL_W]),
            .ctl_i      (ctl),
            .cnt_buf_i  (r_q.cntb[t]),
            .cmp_buf_i  (r_q.cmpb[t]),
            .cnt_o      (live[t]),
            .level_o    (level[t])
        );
    end

    assign pwm_out = level[NUM_PINS-1:0];

    // R2: the gap between timer 0's field and timer 1's field reads zero
    a_r2_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(A_CTRL)) |-> (rd_data[7:4] == 4'b0));

endmodule

// File: tb/pwm_timer_bank_test.sv
module pwm_timer_bank_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        int ch; int pre; int sel; int cnt; int cmp; int inv; int exp_hi;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{0, 0, 0, 9, 4, 0, 32},
        '{2, 2, 1, 4, 2, 0, 96},
        '{1, 0, 3, 3, 3, 0, 0},
        '{0, 0, 0, 9, 4, 1, 48},
        '{3, 1, 0, 2, 0, 0, 0},
        '{3, 0, 0, 5, 5, 1, 48}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] sh_pre  = '0;
    logic [9:0]  sh_sel  = '0;
    logic [23:0] sh_ctrl = '0;

    pwm_timer_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_near(input string tag, input int act, input int exp, input int tol);
        n_chk++;
        if (act < exp - tol || act > exp + tol) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        rd_addr = 5'(a);
        #1;
        v = int'(rd_data);
    endtask

    function automatic int fbase(input int ch);
        return (ch == 0) ? 0 : 4 * ch + 4;
    endfunction

    task automatic set_field(input int ch, input logic [3:0] f);
        sh_ctrl[fbase(ch) +: 4] = f;
        wr(2, 32'(sh_ctrl));
    endtask

    task automatic set_pre(input int p, input int v);
        sh_pre[p*8 +: 8] = 8'(v);
        wr(0, 32'(sh_pre));
    endtask

    task automatic set_sel(input int ch, input int v);
        sh_sel[ch*2 +: 2] = 2'(v);
        wr(1, 32'(sh_sel));
    endtask

    // field order: {auto-reload, invert, update, start}
    task automatic load(input int ch, input int cnt, input int cmp,
                        input bit inv, input bit auto_rl, input bit go);
        wr(4 + ch, 32'(cnt));
        wr(9 + ch, 32'(cmp));
        set_field(ch, {auto_rl, inv, 1'b1, 1'b0});
        set_field(ch, {auto_rl, inv, 1'b0, go});
    endtask

    task automatic count_high(input int ch, input int clocks, output int hi);
        hi = 0;
        for (int i = 0; i < clocks; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2, v);  chk("R1 ctrl", v, 0);
        rd(4, v);  chk("R1 count buffer", v, 0);
        rd(16, v); chk("R1 live counter", v, 0);
        chk("R1 pins", int'(pwm_out), 0);

        // R2 field layout: unused bits drop
        wr(2, 32'hFFFF_FFFF);
        rd(2, v); chk("R2 ctrl mask", v, 32'h00FF_FF0F);
        wr(2, 32'h0);
        rd(2, v); chk("R2 ctrl clear", v, 0);

        // R3 buffer readback, live read-only
        wr(5, 32'h0001_BEEF);
        rd(5, v);  chk("R3 count buffer readback", v, 32'hBEEF);
        wr(10, 32'h0000_0123);
        rd(10, v); chk("R3 compare buffer readback", v, 32'h123);
        wr(17, 32'h55);
        rd(17, v); chk("R3 live write ignored", v, 0);

        // R10 buffer write alone leaves active counter; R4 update loads it
        chk("R10 no load before update", v, 0);
        set_field(1, 4'b0010);
        set_field(1, 4'b0000);
        rd(17, v); chk("R4 manual update load", v, 32'hBEEF);
        repeat (50) @(negedge clk);
        rd(17, v); chk("R6 stopped holds", v, 32'hBEEF);

        // Table of duty vectors (R5 R7 R8 R11)
        for (int k = 0; k < 6; k++) begin
            int per;
            per = (VECS[k].cnt + 1) * (2 << VECS[k].sel) * (VECS[k].pre + 1);
            set_pre((VECS[k].ch < 2) ? 0 : 1, VECS[k].pre);
            set_sel(VECS[k].ch, VECS[k].sel);
            load(VECS[k].ch, VECS[k].cnt, VECS[k].cmp, VECS[k].inv[0], 1'b1, 1'b1);
            repeat (2 * per) @(negedge clk);
            count_high(VECS[k].ch, 4 * per, hi);
            chk($sformatf("R7 R8 R11 R5 vector %0d high cycles", k), hi, VECS[k].exp_hi);
            set_field(VECS[k].ch, 4'b0000);
        end

        // R6 rate: prescale 0, divide by 2 -> one step per 2 clocks
        set_pre(0, 0);
        set_sel(0, 0);
        load(0, 100, 0, 1'b0, 1'b0, 1'b1);
        repeat (40) @(negedge clk);
        rd(16, v); chk_near("R6 down-count rate", v, 80, 2);
        set_field(0, 4'b0000);

        // R9 one-shot holds at zero, output low
        load(0, 3, 1, 1'b0, 1'b0, 1'b1);
        repeat (40) @(negedge clk);
        rd(16, v); chk("R9 one-shot at zero", v, 0);
        chk("R9 one-shot pin low", int'(pwm_out[0]), 0);
        repeat (20) @(negedge clk);
        rd(16, v); chk("R9 still zero", v, 0);
        set_field(0, 4'b0000);

        // R10 new buffers take effect at the next auto-reload
        load(0, 9, 4, 1'b0, 1'b1, 1'b1);
        repeat (20) @(negedge clk);
        wr(4, 32'd19);
        wr(9, 32'd2);
        rd(16, v);
        n_chk++;
        if (v > 9) begin
            n_bad++;
            $display("FAIL R10 count before reload actual=%0d expected=<=9", v);
        end
        repeat (80) @(negedge clk);
        count_high(0, 160, hi);
        chk("R10 R8 new period after reload", hi, 16);
        set_field(0, 4'b0000);

        // R12 internal timer counts
        set_pre(1, 0);
        set_sel(4, 0);
        load(4, 200, 0, 1'b0, 1'b0, 1'b1);
        repeat (40) @(negedge clk);
        rd(20, v); chk_near("R12 internal timer live count", v, 180, 2);
        chk("R12 no pin for timer 4", int'(pwm_out), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule